// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block watches the already-synchronized single-bit output of an analog comparator and raises an interrupt request when a software-chosen event appears on it. Three events can be chosen: any change of level, a high-to-low transition, or a low-to-high transition. A fourth mode code is reserved and never produces an event.

A single byte-wide control/status register holds a sticky event flag, a local interrupt enable and a two-bit mode field. Software reaches this register through a simple write strobe with write data and a read data bus that always shows the current contents. The flag is cleared in two ways. The CPU's vectoring logic can pulse an acknowledge, or software can write a one to the flag position. The request toward the CPU is qualified by both the local enable and a global interrupt enable input, and it leaves the block through a register.

Top module: `cmp_evt_irq`

## Requirements
- R1: With mode code 2'b00, any change of `cmp_in` between two consecutive clock samples sets the flag (read data bit 4).
- R2: With mode code 2'b10, a 1-to-0 change of `cmp_in` sets the flag, and a 0-to-1 change does not.
- R3: With mode code 2'b11, a 0-to-1 change of `cmp_in` sets the flag, and a 1-to-0 change does not.
- R4: With mode code 2'b01 (reserved), no change of `cmp_in` ever sets the flag.
- R5: After each clock edge, `irq` equals flag AND enable (read data bit 3), both taken as they stand after that edge, AND `gie` as it was sampled at that edge.
- R6: A clock edge with `vec_ack` high clears the flag.
- R7: A write with bit 4 of `reg_wdata` at one clears the flag. A write with bit 4 at zero leaves the flag unchanged. Every write loads the enable from bit 3 and the mode from bits 1:0.
- R8: `reg_rdata` shows the flag at bit 4, the enable at bit 3 and the mode at bits 1:0. Bit 2 and bits 7:5 always read zero.
- R9: When an event and a clear (by acknowledge or by a write of one) fall on the same edge, the flag ends at one. The event is judged with the mode held before that edge.
- R10: A clock edge with `rst` high clears the flag, the enable, the mode and `irq`. It also takes the current `cmp_in` as history, so a steady input after reset produces no event.
- R11: A read-modify-write that reads the flag as one and writes the value back clears the flag as a side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Synchronized comparator output |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Acknowledge from the CPU for this interrupt vector |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `cmp_in` is already synchronous to `clk`, so its value sampled at each edge is the level the block compares against its history. They also assume that `rst` is high at the first clock edge, so that the checker's own one-cycle history of `cmp_in` and `gie` matches the block's. The bench drives every input only just after a falling edge and holds it across the next rising edge. Random phases keep `vec_ack` and writes sparse but unconstrained in value, and this includes the reserved mode code.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evt_mode_e;

  localparam int FLAG_POS   = 4;
  localparam int ENA_POS    = 3;
  localparam int RSVD_POS   = 2;
  localparam int MODE_LSB   = 0;
  localparam int MODE_WIDTH = 2;

endpackage

// File: rtl/cmp_edge_det.sv
module cmp_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise,
  output logic fall
);

  logic hist_q;

  // history loads the live input on reset, so no event follows reset
  always_ff @(posedge clk) begin
    hist_q <= sig_in;
  end

  always_comb begin
    rise = 1'b0;
    fall = 1'b0;
    if (!rst) begin
      rise = sig_in & ~hist_q;
      fall = ~sig_in & hist_q;
    end
  end

endmodule

// File: rtl/cmp_evt_sel.sv
module cmp_evt_sel
  import cmp_irq_pkg::*;
(
  input  logic      rise,
  input  logic      fall,
  input  evt_mode_e mode,
  output logic      evt
);

  always_comb begin
    unique case (mode)
      MODE_ANY:  evt = rise | fall;
      MODE_FALL: evt = fall;
      MODE_RISE: evt = rise;
      default:   evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg
  import cmp_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic              gie,
  input  logic              ack,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output evt_mode_e         mode,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int MODE_MSB = MODE_LSB + MODE_WIDTH - 1;

  logic      flag_q, flag_d;
  logic      ena_q, ena_d;
  evt_mode_e mode_q, mode_d;
  logic      irq_q;
  logic      clr;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:FLAG_POS+1], wdata[RSVD_POS]};

  assign clr = ack | (wr & wdata[FLAG_POS]);

  always_comb begin
    flag_d = flag_q;
    if (evt)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    ena_d  = wr ? wdata[ENA_POS] : ena_q;
    mode_d = wr ? evt_mode_e'(wdata[MODE_MSB:MODE_LSB]) : mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ena_q  <= 1'b0;
      mode_q <= MODE_ANY;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ena_q  <= ena_d;
      mode_q <= mode_d;
      irq_q  <= flag_d & ena_d & gie;
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[FLAG_POS]          = flag_q;
    rdata[ENA_POS]           = ena_q;
    rdata[MODE_MSB:MODE_LSB] = mode_q;
  end

  assign mode = mode_q;
  assign irq  = irq_q;

endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
  import cmp_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_in,
  input  logic              gie,
  input  logic              vec_ack,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  logic      rise, fall, evt;
  evt_mode_e mode;

  cmp_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (cmp_in),
    .rise   (rise),
    .fall   (fall)
  );

  cmp_evt_sel u_sel (
    .rise (rise),
    .fall (fall),
    .mode (mode),
    .evt  (evt)
  );

  cmp_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .gie   (gie),
    .ack   (vec_ack),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .mode  (mode),
    .rdata (reg_rdata),
    .irq   (irq)
  );

endmodule

// File: rtl/cmp_evt_irq_chk.sv
module cmp_evt_irq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_in,
  input logic              gie,
  input logic              vec_ack,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq
);

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (reg_rdata == '0 && !irq));

  assert_reserved_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[1:0] == 2'b01 && !reg_rdata[4]) |=> !reg_rdata[4]);

  assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[1:0] == 2'b11 && cmp_in && !$past(cmp_in)) |=> reg_rdata[4]);

  assert_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[1:0] == 2'b10 && !cmp_in && $past(cmp_in)) |=> reg_rdata[4]);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && cmp_in == $past(cmp_in)) |=> !reg_rdata[4]);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[4] && cmp_in == $past(cmp_in)) |=> !reg_rdata[4]);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irq == (reg_rdata[4] & reg_rdata[3] & $past(gie)));

endmodule

bind cmp_evt_irq cmp_evt_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmp_in    (cmp_in),
  .gie       (gie),
  .vec_ack   (vec_ack),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq)
);

// File: tb/sim_cmp_evt_irq.sv
module sim_cmp_evt_irq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, cmp_in, gie, vec_ack, reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       m_prev, m_flag, m_en, m_irq;
  logic [1:0] m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_evt_irq u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .gie(gie), .vec_ack(vec_ack),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic evt_of(input logic [1:0] md, input logic cur, input logic prv);
    case (md)
      2'b00:   return cur != prv;
      2'b10:   return prv & ~cur;
      2'b11:   return cur & ~prv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] model_rd();
    return {3'b000, m_flag, m_en, 1'b0, m_mode};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic ev, nf, ne;
    logic [1:0] nm;
    if (rst) begin
      m_flag = 0; m_en = 0; m_mode = 2'b00; m_irq = 0;
    end else begin
      ev = evt_of(m_mode, cmp_in, m_prev);
      nf = ev ? 1'b1 : ((vec_ack | (reg_wr & reg_wdata[4])) ? 1'b0 : m_flag);
      ne = reg_wr ? reg_wdata[3] : m_en;
      nm = reg_wr ? reg_wdata[1:0] : m_mode;
      m_flag = nf; m_en = ne; m_mode = nm;
      m_irq = nf & ne & gie;
    end
    m_prev = cmp_in;
  endtask

  // one clock: drive, let the edge pass, compare at the falling edge
  task automatic cyc(input string req, input logic c, input logic g,
                     input logic a, input logic w, input logic [7:0] d);
    cmp_in = c; gie = g; vec_ack = a; reg_wr = w; reg_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(req, reg_rdata, model_rd());
    chk(req, {7'b0, irq}, {7'b0, m_irq});
    reg_wr = 1'b0; vec_ack = 1'b0;
  endtask

  task automatic do_reset(input logic c);
    rst = 1'b1;
    cyc("R10", c, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc("R10", c, 1'b0, 1'b0, 1'b0, 8'h00);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd1234));
    rst = 1'b1; cmp_in = 0; gie = 0; vec_ack = 0; reg_wr = 0; reg_wdata = 0;
    m_prev = 0; m_flag = 0; m_en = 0; m_mode = 0; m_irq = 0;
    @(negedge clk);

    // R10: reset state, and a high input held through reset is not an event
    do_reset(1'b1);
    chk("R10", reg_rdata, 8'h00);
    cyc("R10", 1, 1, 0, 0, 8'h00);
    cyc("R10", 1, 1, 0, 1, 8'h08);
    cyc("R10", 1, 1, 0, 0, 8'h00);
    chk("R10", reg_rdata, 8'h08);

    // R4: reserved mode never sets the flag
    cyc("R4", 1, 1, 0, 1, 8'h09);
    for (int i = 0; i < 6; i++) cyc("R4", i[0], 1, 0, 0, 8'h00);
    chk("R4", reg_rdata, 8'h09);

    // R1: toggle mode, both directions
    cyc("R1", 0, 1, 0, 1, 8'h08);
    cyc("R1", 1, 1, 0, 0, 8'h00);
    chk("R1", reg_rdata, 8'h18);
    chk("R5", {7'b0, irq}, 8'h01);
    cyc("R7", 1, 1, 0, 1, 8'h18);
    chk("R7", reg_rdata, 8'h08);
    cyc("R1", 0, 1, 0, 0, 8'h00);
    chk("R1", reg_rdata, 8'h18);

    // R7: a zero in the flag position keeps the flag
    cyc("R7", 0, 1, 0, 1, 8'h08);
    chk("R7", reg_rdata, 8'h18);

    // R5: global enable low blocks the request
    cyc("R5", 0, 0, 0, 0, 8'h00);
    chk("R5", {7'b0, irq}, 8'h00);

    // R6: acknowledge clears
    cyc("R6", 0, 1, 1, 0, 8'h00);
    chk("R6", reg_rdata, 8'h08);
    chk("R6", {7'b0, irq}, 8'h00);

    // R2: falling mode
    cyc("R2", 0, 1, 0, 1, 8'h0A);
    cyc("R2", 1, 1, 0, 0, 8'h00);
    chk("R2", reg_rdata, 8'h0A);
    cyc("R2", 0, 1, 0, 0, 8'h00);
    chk("R2", reg_rdata, 8'h1A);

    // R3: rising mode
    cyc("R3", 0, 1, 0, 1, 8'h1B);
    chk("R3", reg_rdata, 8'h0B);
    cyc("R3", 1, 1, 0, 0, 8'h00);
    chk("R3", reg_rdata, 8'h1B);
    cyc("R3", 1, 1, 1, 0, 8'h00);
    cyc("R3", 0, 1, 0, 0, 8'h00);
    chk("R3", reg_rdata, 8'h0B);

    // R9: event and clear on one edge, set wins (acknowledge and write forms)
    cyc("R9", 1, 1, 1, 0, 8'h00);
    chk("R9", reg_rdata, 8'h1B);
    cyc("R9", 0, 1, 1, 0, 8'h00);
    cyc("R9", 1, 1, 0, 1, 8'h18);
    chk("R9", reg_rdata, 8'h18);

    // R11: read-modify-write to change mode clears a pending flag
    cyc("R11", 1, 1, 0, 1, 8'h0B);
    cyc("R11", 0, 1, 0, 0, 8'h00);
    cyc("R11", 1, 1, 0, 0, 8'h00);
    rd = reg_rdata;
    chk("R11", rd, 8'h1B);
    cyc("R11", 1, 1, 0, 1, (rd & 8'hFC) | 8'h02);
    chk("R11", reg_rdata, 8'h0A);

    // R8: reserved bits read zero after writing all ones
    cyc("R8", 1, 1, 0, 1, 8'hFF);
    chk("R8", reg_rdata, 8'h0B);

    // R10: reset mid-run with input low
    do_reset(1'b0);
    chk("R10", reg_rdata, 8'h00);
    chk("R10", {7'b0, irq}, 8'h00);

    // random phase against the model, all requirements
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      rst = (r[31:24] == 8'h00);
      cyc("R1-R11 random", r[0] ^ r[1] ^ r[5], r[2] | r[3], r[4] & r[6] & r[7],
          (r[10:8] == 3'b000), r[23:16]);
    end
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule